// File: doc/BRIEF.md
# Framing Error Event Counter

This block keeps a 12-bit tally of receive-side framing trouble for a T1 framer. Each frame the framer may raise single-cycle strobes: a framing-bit error seen against the terminal framing pattern (D4 superframe), a framing-bit error seen against the framing pattern sequence (ESF extended superframe), or a multiframe found out of synchronisation. Two control bits decide which strobe is counted. The count-select bit chooses between framing-bit errors and out-of-sync multiframes. When framing-bit errors are counted, the framing-mode bit picks the pattern: Ft errors in D4, FPS errors in ESF.

The running tally saturates rather than wraps. A host latch strobe moves the running tally into a held copy and restarts the running tally in the same cycle, so no event is lost between intervals. The held copy is shown as two byte registers. The upper register also carries, in its low nibble, four bits that belong to a neighbouring path code violation counter. That nibble arrives on an input and is passed through unchanged.

Top module: `fec_counter_top`

## Requirements
- R1: A synchronous active-high reset clears the running tally and the held copy, so both byte registers show zero count bits after reset.
- R2: With count-select 0 and framing-mode 0 (D4), each cycle with the Ft error strobe high adds one to the tally. The FPS and out-of-sync strobes have no effect.
- R3: With count-select 0 and framing-mode 1 (ESF), each cycle with the FPS error strobe high adds one to the tally. The Ft and out-of-sync strobes have no effect.
- R4: With count-select 1, each cycle with the out-of-sync multiframe strobe high adds one to the tally. Both framing-bit error strobes have no effect, whatever the framing mode.
- R5: In a cycle with the latch strobe high, the held copy takes the running tally as it stood before that cycle, and the running tally restarts at 1 if the selected strobe is high in that cycle, else at 0. The byte registers show the new held copy one clock later.
- R6: The byte registers change only one clock after a latch strobe (or reset). Events alone never change them.
- R7: Count layout: the upper register bits 7..4 hold count bits 11..8, so bit 7 is the count MSB. The lower register bits 7..0 hold count bits 7..0, so bit 0 is the count LSB.
- R8: Bits 3..0 of the upper register always equal the 4-bit path code violation nibble input, combinationally, and the counter never affects them.
- R9: The running tally stops at 0xFFF and does not wrap. Further events leave it at 0xFFF until a latch or reset.
- R10: At most one count is added per clock, even when several strobes are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ft_err_p | input | 1 | Ft pattern error strobe (D4), one cycle per event |
| fps_err_p | input | 1 | FPS pattern error strobe (ESF), one cycle per event |
| oos_mf_p | input | 1 | Out-of-sync multiframe strobe, one cycle per event |
| cnt_oos_sel | input | 1 | 0: count framing-bit errors, 1: count out-of-sync multiframes |
| esf_sel | input | 1 | 0: D4 framing, 1: ESF framing |
| latch_req | input | 1 | Host strobe: copy the tally to the registers and restart it |
| pcv_nib_in | input | 4 | Nibble from the path code violation counter |
| cnt_reg_hi | output | 8 | Upper register: count bits 11..8 in bits 7..4, PCV nibble in bits 3..0 |
| cnt_reg_lo | output | 8 | Lower register: count bits 7..0 |

## Verification
The bench builds the block with its default widths: 8-bit registers, a 4-bit side nibble and so a 12-bit count. With these widths the ceiling of 0xFFF is about four thousand events away, so the run can drive the tally into saturation and prove it holds there. A mid-range value such as 0xA5C lets the test tell the two register halves apart and confirm the bit layout. All three strobes are driven in every select and mode combination, including cycles where several are high and cycles where a latch and an event coincide.

// File: rtl/fec_pkg.sv
package fec_pkg;

    localparam int REG_W  = 8;
    localparam int SIDE_W = 4;
    localparam int CNT_W  = 2 * REG_W - SIDE_W;

    typedef logic [CNT_W-1:0] count_t;

    localparam count_t CNT_MAX = '1;

    typedef struct packed {
        logic ft;
        logic fps;
        logic oos;
    } evt_t;

    typedef struct packed {
        logic cnt_oos;
        logic esf;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_FT  = 2'd0,
        SRC_FPS = 2'd1,
        SRC_OOS = 2'd2
    } src_e;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } regpair_t;

    function automatic src_e pick_src(ctrl_t c);
        if (c.cnt_oos)
            return SRC_OOS;
        else if (c.esf)
            return SRC_FPS;
        else
            return SRC_FT;
    endfunction

    function automatic count_t sat_inc(count_t c, logic en);
        if (en && (c != CNT_MAX))
            return c + count_t'(1);
        else
            return c;
    endfunction

endpackage

// File: rtl/fec_event_sel.sv
module fec_event_sel
    import fec_pkg::*;
(
    input  evt_t  evt,
    input  ctrl_t ctrl,
    output logic  hit
);

    src_e src;

    always_comb begin
        src = pick_src(ctrl);
        case (src)
            SRC_FT:  hit = evt.ft;
            SRC_FPS: hit = evt.fps;
            SRC_OOS: hit = evt.oos;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fec_sat_counter.sv
module fec_sat_counter
    import fec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   inc,
    input  logic   restart,
    output count_t q
);

    count_t q_nxt;

    always_comb begin
        if (restart)
            q_nxt = inc ? count_t'(1) : '0;
        else
            q_nxt = sat_inc(q, inc);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_nxt;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (!restart && q == CNT_MAX) |=> (q == CNT_MAX));

    assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (q == $past(q) || q == $past(q) + count_t'(1)));

    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        restart |=> (q <= count_t'(1)));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/fec_hold_reg.sv
module fec_hold_reg
    import fec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  count_t d,
    output count_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    assert_hold_capture_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

endmodule

// File: rtl/fec_counter_top.sv
module fec_counter_top
    import fec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ft_err_p,
    input  logic              fps_err_p,
    input  logic              oos_mf_p,
    input  logic              cnt_oos_sel,
    input  logic              esf_sel,
    input  logic              latch_req,
    input  logic [SIDE_W-1:0] pcv_nib_in,
    output logic [REG_W-1:0]  cnt_reg_hi,
    output logic [REG_W-1:0]  cnt_reg_lo
);

    localparam int HI_CNT_W = CNT_W - REG_W;

    evt_t     evt;
    ctrl_t    ctrl;
    logic     hit;
    count_t   running;
    count_t   held;
    regpair_t regs;

    assign evt  = '{ft: ft_err_p, fps: fps_err_p, oos: oos_mf_p};
    assign ctrl = '{cnt_oos: cnt_oos_sel, esf: esf_sel};

    fec_event_sel u_sel (
        .evt  (evt),
        .ctrl (ctrl),
        .hit  (hit)
    );

    fec_sat_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (hit),
        .restart (latch_req),
        .q       (running)
    );

    fec_hold_reg u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (latch_req),
        .d    (running),
        .q    (held)
    );

    genvar gi;
    generate
        for (gi = 0; gi < REG_W; gi++) begin : g_lo
            assign regs.lo[gi] = held[gi];
        end
        for (gi = 0; gi < HI_CNT_W; gi++) begin : g_hi
            assign regs.hi[SIDE_W + gi] = held[REG_W + gi];
        end
        for (gi = 0; gi < SIDE_W; gi++) begin : g_side
            assign regs.hi[gi] = pcv_nib_in[gi];
        end
    endgenerate

    assign cnt_reg_hi = regs.hi;
    assign cnt_reg_lo = regs.lo;

    assert_d4_ignores_R2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_oos_sel && !esf_sel && !ft_err_p && !latch_req) |=> $stable(running));

    assert_esf_ignores_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_oos_sel && esf_sel && !fps_err_p && !latch_req) |=> $stable(running));

    assert_oos_ignores_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_oos_sel && !oos_mf_p && !latch_req) |=> $stable(running));

    assert_regs_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !latch_req |=> ($stable(cnt_reg_lo) && $stable(cnt_reg_hi[REG_W-1:SIDE_W])));

endmodule

// File: tb/fec_counter_top_bench.sv
module fec_counter_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ft = 1'b0, fps = 1'b0, oos = 1'b0;
    logic       sel = 1'b0, esf = 1'b0, latch = 1'b0;
    logic [3:0] nib = 4'h0;
    logic [7:0] reg_hi, reg_lo;

    int n_tests = 0;
    int n_fail  = 0;
    int m_run   = 0;
    int m_held  = 0;

    always #10 clk = ~clk;

    fec_counter_top u_fec_counter_top (
        .clk         (clk),
        .rst         (rst),
        .ft_err_p    (ft),
        .fps_err_p   (fps),
        .oos_mf_p    (oos),
        .cnt_oos_sel (sel),
        .esf_sel     (esf),
        .latch_req   (latch),
        .pcv_nib_in  (nib),
        .cnt_reg_hi  (reg_hi),
        .cnt_reg_lo  (reg_lo)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(string tag);
        bit ev;
        @(posedge clk);
        ev = sel ? oos : (esf ? fps : ft);
        if (rst) begin
            m_run = 0; m_held = 0;
        end else if (latch) begin
            m_held = m_run;
            m_run  = ev ? 1 : 0;
        end else if (ev && m_run < 4095) begin
            m_run++;
        end
        @(negedge clk);
        check({tag, " lo"}, int'(reg_lo), m_held & 8'hFF);
        check({tag, " hi"}, int'(reg_hi), (((m_held >> 8) & 4'hF) << 4) | int'(nib));
        ft = 0; fps = 0; oos = 0; latch = 0;
    endtask

    task automatic pulses(string tag, int n, bit a, bit b, bit c);
        for (int i = 0; i < n; i++) begin
            ft = a; fps = b; oos = c;
            tick(tag);
            tick(tag);
        end
    endtask

    task automatic do_latch(string tag);
        latch = 1;
        tick(tag);
        tick(tag);
    endtask

    initial begin
        fork
            begin
                #(20 * 150000);
                n_fail++;
                $display("FAIL watchdog expired");
            end
            begin
                @(negedge clk);
                rst = 1;
                tick("R1 reset");
                tick("R1 reset");
                rst = 0;
                tick("R1 after reset");
                check("R1 reset lo zero", int'(reg_lo), 0);

                // R2: D4 framing errors
                sel = 0; esf = 0;
                pulses("R2 ft", 5, 1, 0, 0);
                pulses("R2 fps ignored", 3, 0, 1, 0);
                pulses("R2 oos ignored", 3, 0, 0, 1);
                do_latch("R2 latch");
                check("R2 count five", int'(reg_lo), 5);

                // R3: ESF framing errors
                esf = 1;
                pulses("R3 fps", 7, 0, 1, 0);
                pulses("R3 ft ignored", 4, 1, 0, 0);
                do_latch("R3 latch");
                check("R3 count seven", int'(reg_lo), 7);

                // R4: out-of-sync multiframes
                sel = 1;
                pulses("R4 oos", 6, 0, 0, 1);
                pulses("R4 framing ignored", 4, 1, 1, 0);
                esf = 0;
                pulses("R4 framing ignored d4", 4, 1, 1, 0);
                do_latch("R4 latch");
                check("R4 count six", int'(reg_lo), 6);

                // R10: simultaneous strobes count once per cycle
                for (int i = 0; i < 9; i++) begin
                    ft = 1; fps = 1; oos = 1;
                    tick("R10 multi");
                end
                do_latch("R10 latch");
                check("R10 count nine", int'(reg_lo), 9);

                // R5: event in latch cycle goes to the new interval
                sel = 0; esf = 0;
                pulses("R5 pre", 3, 1, 0, 0);
                ft = 1; latch = 1;
                tick("R5 latch with event");
                check("R5 old interval", int'(reg_lo), 3);
                pulses("R5 post", 2, 1, 0, 0);
                do_latch("R5 latch2");
                check("R5 new interval", int'(reg_lo), 3);

                // R7/R8: layout with 0xA5C and varying nibble
                nib = 4'h3;
                for (int i = 0; i < 12'hA5C; i++) begin
                    ft = 1;
                    tick("R6 quiet while counting");
                end
                nib = 4'h9;
                do_latch("R7 latch");
                check("R7 hi", int'(reg_hi), 8'hA9);
                check("R7 lo", int'(reg_lo), 8'h5C);
                nib = 4'h6;
                tick("R8 nibble");
                check("R8 nibble", int'(reg_hi[3:0]), 6);

                // R9: saturation
                for (int i = 0; i < 4100; i++) begin
                    ft = 1;
                    tick("R9 saturate");
                end
                do_latch("R9 latch");
                check("R9 max lo", int'(reg_lo), 8'hFF);
                check("R9 max hi", int'(reg_hi[7:4]), 4'hF);

                // R1: reset clears held value
                rst = 1;
                tick("R1 reset again");
                rst = 0;
                tick("R1 cleared");
                check("R1 cleared lo", int'(reg_lo), 0);
                check("R1 cleared hi", int'(reg_hi[7:4]), 0);
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule